// File: doc/BRIEF.md
# Dual-Mode Serial Memory Streamer

This block sends the contents of a small on-chip byte array out of a serial data pin without any bus master. After reset it sits in a transmit-only state and counts pulses on a dedicated transmit clock input. The first nine pulses only align it. From the tenth pulse on, every rising edge of the transmit clock moves the pin to the next bit. Bytes go out most significant bit first. Each byte takes nine pulses: eight carry data and one is an idle slot in which the pin is released. The address advances by one after every byte and wraps from the last location back to zero.

The bus clock line is watched all the time. While it stays high, streaming goes on. A high-to-low transition on it switches the block, for good, into bidirectional mode. In that mode the pin is never driven by this block, and control passes to a bus slave interface outside the block. Only a reset brings the block back to transmit-only.

All pin inputs are sampled by a fast system clock through two-flop synchronizers, and edges are found digitally. The data output comes with a drive enable meant for an open-drain pad. The array image is a parameter.

Top module: `dual_mode_streamer`

## Requirements
- R1: While `rst_n` is low and just after it rises, `bidir_mode`, `sda_oe` and `sda_out` are all 0.
- R2: The first nine rising edges of `tx_clk_pin` after reset leave `sda_oe` at 0. They only advance an internal preamble count.
- R3: On the tenth rising edge of `tx_clk_pin`, `sda_oe` goes to 1 and `sda_out` shows bit 7 of the byte at address 0.
- R4: A byte occupies nine transmit clock rising edges. Slots 0 to 7 drive bits 7 down to 0 of the byte. Slot 8 is the idle slot, with `sda_oe` = 0 and `sda_out` = 0.
- R5: After the idle slot, the next rising edge starts the byte at the next address. Whenever `sda_oe` is 0, `sda_out` is 0.
- R6: After the byte at address 127 (the last of 128 locations), the stream continues with the byte at address 0.
- R7: A falling edge on `bus_clk_pin` sets `bidir_mode` to 1 and forces `sda_oe` to 0. Both stay that way until reset, whatever the transmit clock does. A falling edge wins over a transmit rising edge seen in the same cycle.
- R8: While the synchronized bus clock is low and no falling edge has happened (it was low at reset release), transmit clock edges are ignored. Neither the preamble count nor the stream position changes.
- R9: Pin changes reach the outputs after exactly three rising edges of `clk`: two synchronizer stages and one state register.
- R10: A reset taken after bidirectional mode returns the block to transmit-only with a fresh nine-pulse preamble and address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_clk_pin | input | 1 | Transmit clock pin, asynchronous |
| bus_clk_pin | input | 1 | Bus clock line, asynchronous |
| sda_out | output | 1 | Serial data value, 0 whenever not driving |
| sda_oe | output | 1 | Drive enable for the open-drain data pad |
| bidir_mode | output | 1 | 1 once bidirectional mode has been entered |

## Verification
The array is filled with a non-repeating pattern so that a byte sent from the wrong address or in the wrong bit order shows up at once. The stream runs long enough to pass address 127, so the wrap is seen against fresh data. A falling edge on the bus clock in the middle of a byte, followed by more transmit pulses, separates a mode flag that is truly sticky from one that only pauses the stream. A second reset taken with the bus clock low, then pulses before and after the line rises, separates gating by bus level from the falling-edge switch and shows that the preamble restarts.

// File: rtl/dms_pkg.sv
package dms_pkg;
  // Width of one stream slot counter that covers data slots plus the idle slot.
  function automatic int unsigned slot_width(input int unsigned byte_w);
    return $clog2(byte_w + 1);
  endfunction

  // Bit of the current byte shown in a given slot, MSB first; 0 for the idle slot.
  function automatic int unsigned msb_first_pos(input int unsigned slot,
                                                input int unsigned byte_w);
    if (slot < byte_w) return byte_w - 1 - slot;
    return 0;
  endfunction
endpackage

// File: rtl/dms_sync.sv
module dms_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dms_edge.sv
module dms_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end

  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;
endmodule

// File: rtl/dms_seq.sv
module dms_seq #(
  parameter int ADDR_W      = 7,
  parameter int BYTE_W      = 8,
  parameter int SYNC_PULSES = 9,
  localparam int CNT_W      = $clog2(SYNC_PULSES + 1),
  localparam int SLOT_W     = dms_pkg::slot_width(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_rise,
  input  logic              bus_high,
  input  logic              bus_fall,
  output logic              pre_done,
  output logic              started,
  output logic              bidir,
  output logic [ADDR_W-1:0] addr,
  output logic [SLOT_W-1:0] slot
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [SLOT_W-1:0] IDLE_SLOT = SLOT_W'(BYTE_W);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    return (a == LAST_ADDR) ? '0 : a + 1'b1;
  endfunction

  logic [CNT_W-1:0] sync_cnt;
  logic             advance;
  logic             byte_end;

  assign pre_done = (sync_cnt == CNT_W'(SYNC_PULSES));
  assign advance  = tx_rise & bus_high & ~bidir & ~bus_fall;
  assign byte_end = advance & started & (slot == IDLE_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_cnt <= '0;
      started  <= 1'b0;
      bidir    <= 1'b0;
      addr     <= '0;
      slot     <= '0;
    end else if (bus_fall) begin
      bidir <= 1'b1;
    end else if (advance) begin
      if (!pre_done) begin
        sync_cnt <= sync_cnt + 1'b1;
      end else if (!started) begin
        started <= 1'b1;
      end else if (slot == IDLE_SLOT) begin
        slot <= '0;
        addr <= next_addr(addr);
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  assert_bidir_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bidir |=> bidir);

  assert_hold_bus_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_high && !bus_fall) |=> ($stable(addr) && $stable(slot) && $stable(started)));

  assert_addr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && addr == LAST_ADDR) |=> (addr == '0));

  assert_byte_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && addr != LAST_ADDR) |=> (addr == $past(addr) + 1'b1 && slot == '0));
endmodule

// File: rtl/dms_rom.sv
module dms_rom #(
  parameter int ADDR_W = 7,
  parameter int BYTE_W = 8,
  parameter logic [(1<<ADDR_W)*BYTE_W-1:0] MEM_INIT = '0,
  localparam int SLOT_W = dms_pkg::slot_width(BYTE_W)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SLOT_W-1:0] slot,
  output logic              bit_out
);
  logic [BYTE_W-1:0] cur_byte;

  assign cur_byte = MEM_INIT[int'(addr)*BYTE_W +: BYTE_W];
  assign bit_out  = cur_byte[dms_pkg::msb_first_pos(int'(slot), BYTE_W)];
endmodule

// File: rtl/dual_mode_streamer.sv
module dual_mode_streamer #(
  parameter int ADDR_W      = 7,
  parameter int BYTE_W      = 8,
  parameter int SYNC_PULSES = 9,
  parameter int SYNC_STAGES = 2,
  parameter logic [(1<<ADDR_W)*BYTE_W-1:0] MEM_INIT = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_clk_pin,
  input  logic bus_clk_pin,
  output logic sda_out,
  output logic sda_oe,
  output logic bidir_mode
);
  localparam int SLOT_W = dms_pkg::slot_width(BYTE_W);

  logic              tx_s, bus_s;
  logic              tx_rise, tx_fall_unused;
  logic              bus_rise_unused, bus_fall;
  logic              pre_done, started, bidir;
  logic [ADDR_W-1:0] addr;
  logic [SLOT_W-1:0] slot;
  logic              rom_bit;
  logic              data_slot;

  dms_sync #(.STAGES(SYNC_STAGES)) u_sync_tx (
    .clk(clk), .rst_n(rst_n), .d(tx_clk_pin), .q(tx_s));
  dms_sync #(.STAGES(SYNC_STAGES)) u_sync_bus (
    .clk(clk), .rst_n(rst_n), .d(bus_clk_pin), .q(bus_s));

  dms_edge u_edge_tx (
    .clk(clk), .rst_n(rst_n), .lvl(tx_s), .rise(tx_rise), .fall(tx_fall_unused));
  dms_edge u_edge_bus (
    .clk(clk), .rst_n(rst_n), .lvl(bus_s), .rise(bus_rise_unused), .fall(bus_fall));

  dms_seq #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .SYNC_PULSES(SYNC_PULSES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tx_rise(tx_rise), .bus_high(bus_s),
    .bus_fall(bus_fall), .pre_done(pre_done), .started(started),
    .bidir(bidir), .addr(addr), .slot(slot));

  dms_rom #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .MEM_INIT(MEM_INIT)) u_rom (
    .addr(addr), .slot(slot), .bit_out(rom_bit));

  assign data_slot  = (slot < SLOT_W'(BYTE_W));
  assign sda_oe     = started & ~bidir & data_slot;
  assign sda_out    = sda_oe & rom_bit;
  assign bidir_mode = bidir;

  assert_quiet_preamble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_done |-> !sda_oe);

  assert_idle_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == SLOT_W'(BYTE_W)) |-> (!sda_oe && !sda_out));

  assert_bidir_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bidir_mode |-> !sda_oe);

  assert_first_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(started) |-> (sda_oe && addr == '0 && slot == '0));

  assert_release_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sda_oe |-> !sda_out);
endmodule

// File: tb/dual_mode_streamer_test.sv
module dual_mode_streamer_test;
  localparam int ADDR_W = 7;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BYTE_W = 8;
  localparam int SYNC   = 9;
  localparam int LAT    = 3;

  function automatic logic [DEPTH*BYTE_W-1:0] build_image();
    logic [DEPTH*BYTE_W-1:0] img;
    img = '0;
    for (int i = 0; i < DEPTH; i++) img[i*BYTE_W +: BYTE_W] = 8'((i * 73 + 29) ^ (i >> 2));
    return img;
  endfunction
  localparam logic [DEPTH*BYTE_W-1:0] IMAGE = build_image();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_clk_pin = 1'b0;
  logic bus_clk_pin = 1'b1;
  logic sda_out, sda_oe, bidir_mode;

  always #10 clk = ~clk;

  dual_mode_streamer #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .SYNC_PULSES(SYNC),
                       .MEM_INIT(IMAGE)) uut (
    .clk(clk), .rst_n(rst_n), .tx_clk_pin(tx_clk_pin), .bus_clk_pin(bus_clk_pin),
    .sda_out(sda_out), .sda_oe(sda_oe), .bidir_mode(bidir_mode));

  int compared = 0;
  int mismatched = 0;

  logic drv_rst = 1'b0, drv_tx = 1'b0, drv_bus = 1'b1;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  int  m_cnt, m_slot, m_addr;
  bit  m_started, m_bidir, m_prev_tx, m_prev_bus, m_wrapped;
  bit  phase_b;

  task automatic model_reset();
    m_cnt = 0; m_slot = 0; m_addr = 0;
    m_started = 0; m_bidir = 0; m_prev_tx = 0; m_prev_bus = 0;
  endtask

  task automatic step();
    logic [2:0] e;
    string t;
    logic [2:0] got;
    bit rise, fall, oe, dat;
    string tag;
    @(negedge clk);
    if (exp_q.size() == LAT) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      got = {bidir_mode, sda_oe, sda_out};
      compared++;
      if (got !== e) begin
        mismatched++;
        $display("FAIL %s: {mode,oe,sda} actual %b expected %b at %0t", t, got, e, $time);
      end
    end
    if (!drv_rst && rst_n) begin
      exp_q.delete(); tag_q.delete();
      for (int k = 0; k < LAT - 1; k++) begin
        exp_q.push_back(3'b000); tag_q.push_back(phase_b ? "R10" : "R1");
      end
    end
    rst_n = drv_rst; tx_clk_pin = drv_tx; bus_clk_pin = drv_bus;
    tag = "R5";
    if (!drv_rst) begin
      model_reset();
      tag = phase_b ? "R10" : "R1";
    end else begin
      rise = drv_tx && !m_prev_tx;
      fall = !drv_bus && m_prev_bus;
      if (fall) begin
        m_bidir = 1; tag = "R7";
      end else if (m_bidir) begin
        tag = "R7";
      end else if (rise && !drv_bus) begin
        tag = "R8";
      end else if (rise) begin
        if (m_cnt < SYNC) begin
          m_cnt++; tag = "R2";
        end else if (!m_started) begin
          m_started = 1; tag = phase_b ? "R10" : "R3/R9";
        end else if (m_slot == BYTE_W) begin
          m_slot = 0;
          if (m_addr == DEPTH - 1) begin m_addr = 0; m_wrapped = 1; tag = "R6"; end
          else m_addr++;
        end else begin
          m_slot++;
          tag = (m_slot == BYTE_W) ? "R4" : "R5";
        end
      end else if (!drv_bus) begin
        tag = "R8";
      end else if (m_cnt < SYNC) begin
        tag = "R2";
      end
      if (m_wrapped && m_addr == 0 && tag == "R5") tag = "R6";
      m_prev_tx = drv_tx;
      m_prev_bus = drv_bus;
    end
    oe  = m_started && !m_bidir && (m_slot < BYTE_W);
    dat = oe ? IMAGE[m_addr*BYTE_W + (BYTE_W - 1 - m_slot)] : 1'b0;
    exp_q.push_back({m_bidir, oe, dat});
    tag_q.push_back(tag);
  endtask

  task automatic pulse();
    drv_tx = 1; step(); step();
    drv_tx = 0; step(); step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    model_reset();
    phase_b = 0; m_wrapped = 0;
    // R1: reset held with bus high, then released with transmit clock low
    drv_rst = 0; drv_bus = 1; drv_tx = 0;
    idle(6);
    drv_rst = 1;
    idle(5);
    // R2, R3, R9: preamble and first bit; R4, R5, R6: full pass with wrap
    for (int p = 0; p < SYNC + 1 + DEPTH * (BYTE_W + 1) + 30; p++) pulse();
    // R7: bus clock falls mid-byte, further pulses must stay silent
    drv_tx = 1; step(); step();
    drv_bus = 0; step(); step();
    drv_tx = 0; step(); step();
    for (int p = 0; p < 12; p++) pulse();
    drv_bus = 1; idle(4);
    for (int p = 0; p < 6; p++) pulse();
    // R10 and R8: reset again with the bus clock low
    phase_b = 1; m_wrapped = 0;
    drv_rst = 0; drv_bus = 0; drv_tx = 0;
    idle(5);
    drv_rst = 1;
    idle(4);
    for (int p = 0; p < 6; p++) pulse();
    drv_bus = 1; idle(4);
    for (int p = 0; p < SYNC + 1 + 3 * (BYTE_W + 1) + 4; p++) pulse();
    drv_bus = 0; idle(4);
    for (int p = 0; p < 5; p++) pulse();
    idle(LAT + 2);
    summary();
    $finish;
  end
endmodule